// File: doc/BRIEF.md
# Multi-Mode Capture Timer/Counter

This block is a 16-bit timer/counter built from two 8-bit halves, a low half and a high half. A 2-bit mode input decides how the halves are joined. They can run as two free 8-bit timers. They can run as an 8-bit timer beside an 8-bit counter of external events. They can be chained into one 16-bit timer. They can be chained into one 16-bit event counter. Timer halves advance on the tick of a shared programmable prescaler. Event halves advance on rising edges of an asynchronous count input, which is synchronised first.

Each half compares its count against a writable match value. On the count after a match, the half reloads to zero and raises its own one-cycle interrupt flag. Two capture strobes take snapshots of the running count. In the chained modes both halves form one word, and the low-half strobe captures all 16 bits.

Top module: `dual_half_timer`

## Requirements
- R1: Modes are encoded 0 = two 8-bit timers, 1 = low timer and high event counter, 2 = 16-bit timer, 3 = 16-bit event counter. In the clock where `mode_i` differs from the mode in use, both counts and the prescaler clear to zero, and no flag is raised in that clock.
- R2: With prescale value N, every timer half advances once every N+1 clocks. The first advance comes N+1 clocks after the restart. A write to the prescale value restarts both counts and the prescaler.
- R3: An 8-bit half whose count equals its match value goes to zero on its next count instead of incrementing. Its flag is high for exactly the one clock that follows that count, so a half counts through match+1 values.
- R4: In mode 0, the low and high halves time independently against their own match values, and the low and high flags report them separately.
- R5: In mode 1, the low half times as in R4. The high half counts rising edges of `evt_i`, seen through a two-flop synchroniser, and each edge is counted within three clocks.
- R6: In mode 2, the halves form one 16-bit prescaled timer whose match value is {high match, low match}. Its reload raises `irq_hi_o` only, and `irq_lo_o` stays low.
- R7: In mode 3, the halves form one 16-bit counter of `evt_i` rising edges, with match and flag as in R6.
- R8: A rising edge on a capture strobe copies the count that is held during that clock into the capture output. In modes 0 and 1, `cap_lo_i` captures the low half and `cap_hi_i` captures the high half.
- R9: In modes 2 and 3, a rising edge on `cap_lo_i` captures the low byte of the count into `cap_lo_o` and the high byte into `cap_hi_o`. `cap_hi_i` has no effect.
- R10: After reset, counts and captures are zero, flags are low, the mode is 0, both match values are 0xFF and the prescale value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Configuration select (R1 encoding) |
| pre_wr_i | input | 1 | Load `pre_data_i` as prescale value and restart |
| pre_data_i | input | PRE_W | Prescale value N |
| match_lo_wr_i | input | 1 | Load `match_data_i` as low-half match value |
| match_hi_wr_i | input | 1 | Load `match_data_i` as high-half match value |
| match_data_i | input | HALF_W | Match value write data |
| evt_i | input | 1 | Asynchronous external count input |
| cap_lo_i | input | 1 | Low-half capture strobe |
| cap_hi_i | input | 1 | High-half capture strobe |
| cap_lo_o | output | HALF_W | Low capture value |
| cap_hi_o | output | HALF_W | High capture value |
| irq_lo_o | output | 1 | Low-half match flag |
| irq_hi_o | output | 1 | High-half (or 16-bit) match flag |

## Verification
The timer modes are swept over prescale values 0 to 3 and over match values that include 0 and 255. The captured counts and the flag tallies are compared with floor-division arithmetic, which separates a wrong divide ratio from a wrong reload point. Event modes are driven with bursts of pulses whose sizes fall just below, at and past the match. In mode 1 the prescaled low timer runs at the same time, which exposes swapped enables. The 16-bit modes use match values above 255 so that the carry between halves is exercised. A restart by mode change and an ignored high strobe are checked by the captures that follow them.

// File: rtl/dht_pkg.sv
`timescale 1ns/1ps
package dht_pkg;
    typedef enum logic [1:0] {
        MODE_2X8   = 2'd0,
        MODE_8T_8E = 2'd1,
        MODE_16T   = 2'd2,
        MODE_16E   = 2'd3
    } dht_mode_e;
endpackage

// File: rtl/dht_sync_edge.sv
`timescale 1ns/1ps
module dht_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R5: a synchronised edge yields a single-clock pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/dht_prescaler.sv
`timescale 1ns/1ps
module dht_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == div_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2: after a tick the divider starts a fresh period
    a_r2_tick_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/dht_half.sv
`timescale 1ns/1ps
module dht_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R3: an enabled count without reload advances by one
    a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dual_half_timer.sv
`timescale 1ns/1ps
module dual_half_timer
    import dht_pkg::*;
#(
    parameter int HALF_W = 8,
    parameter int PRE_W  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              pre_wr_i,
    input  logic [PRE_W-1:0]  pre_data_i,
    input  logic              match_lo_wr_i,
    input  logic              match_hi_wr_i,
    input  logic [HALF_W-1:0] match_data_i,
    input  logic              evt_i,
    input  logic              cap_lo_i,
    input  logic              cap_hi_i,
    output logic [HALF_W-1:0] cap_lo_o,
    output logic [HALF_W-1:0] cap_hi_o,
    output logic              irq_lo_o,
    output logic              irq_hi_o
);
    localparam int FULL_W = 2 * HALF_W;

    typedef struct packed {
        dht_mode_e               mode;
        logic [1:0][HALF_W-1:0]  match;
        logic [PRE_W-1:0]        div;
        logic [1:0]              cap_prev;
        logic [1:0][HALF_W-1:0]  cap;
        logic [1:0]              irq;
    } state_t;

    state_t st_d, st_q;

    logic                   restart, wide, pre_tick, evt_tick;
    logic                   en_lo, en_hi8, hit_lo8, hit_hi8, hit16;
    logic [1:0]             half_clr, half_inc, rise;
    logic [1:0][HALF_W-1:0] cnt;
    logic [FULL_W-1:0]      cnt16, match16;

    dht_prescaler #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr_i(restart),
        .div_i(st_q.div), .tick_o(pre_tick)
    );

    dht_sync_edge #(.STAGES(SYNC_STAGES)) u_evt (
        .clk(clk), .rst_n(rst_n), .async_i(evt_i), .rise_o(evt_tick)
    );

    for (genvar g = 0; g < 2; g++) begin : g_half
        dht_half #(.W(HALF_W)) u_half (
            .clk(clk), .rst_n(rst_n), .clr_i(half_clr[g]),
            .inc_i(half_inc[g]), .cnt_o(cnt[g])
        );
    end

    assign restart = pre_wr_i || (dht_mode_e'(mode_i) != st_q.mode);
    assign wide    = st_q.mode[1];
    assign cnt16   = {cnt[1], cnt[0]};
    assign match16 = {st_q.match[1], st_q.match[0]};
    assign en_lo   = (st_q.mode == MODE_16E) ? evt_tick : pre_tick;
    assign en_hi8  = (st_q.mode == MODE_8T_8E) ? evt_tick : pre_tick;
    assign hit_lo8 = en_lo  && (cnt[0] == st_q.match[0]);
    assign hit_hi8 = en_hi8 && (cnt[1] == st_q.match[1]);
    assign hit16   = en_lo  && (cnt16 == match16);
    assign rise    = {cap_hi_i, cap_lo_i} & ~st_q.cap_prev;

    always_comb begin
        half_clr[0] = restart || (wide ? hit16 : hit_lo8);
        half_clr[1] = restart || (wide ? hit16 : hit_hi8);
        half_inc[0] = en_lo;
        half_inc[1] = wide ? (en_lo && (cnt[0] == '1)) : en_hi8;

        st_d          = st_q;
        st_d.mode     = dht_mode_e'(mode_i);
        st_d.cap_prev = {cap_hi_i, cap_lo_i};
        if (pre_wr_i)      st_d.div      = pre_data_i;
        if (match_lo_wr_i) st_d.match[0] = match_data_i;
        if (match_hi_wr_i) st_d.match[1] = match_data_i;

        st_d.irq[0] = !restart && !wide && hit_lo8;
        st_d.irq[1] = !restart && (wide ? hit16 : hit_hi8);

        if (rise[0]) st_d.cap[0] = cnt[0];
        if (wide ? rise[0] : rise[1]) st_d.cap[1] = cnt[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mode     <= MODE_2X8;
            st_q.match[0] <= '1;
            st_q.match[1] <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_lo_o = st_q.cap[0];
    assign cap_hi_o = st_q.cap[1];
    assign irq_lo_o = st_q.irq[0];
    assign irq_hi_o = st_q.irq[1];

    // R1: a restart leaves both halves at zero
    a_r1_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt[0] == '0 && cnt[1] == '0 && !irq_lo_o && !irq_hi_o));

    // R3: the low flag appears exactly when the low half has reloaded
    a_r3_lo_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo_o |-> (cnt[0] == '0));

    // R6: the high flag marks a reload of its half or of the whole word
    a_r6_hi_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi_o |-> (cnt[1] == '0));

    // R6: chained modes never raise the low flag
    a_r6_no_lo_flag_wide: assert property (@(posedge clk) disable iff (!rst_n)
        wide |-> !irq_lo_o);

    // R8: low strobe edge snapshots the low count of that clock
    a_r8_cap_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_lo_i && !st_q.cap_prev[0]) |=> (cap_lo_o == $past(cnt[0])));

    // R9: in chained modes the high capture only moves with the low strobe
    a_r9_hi_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && !(cap_lo_i && !st_q.cap_prev[0])) |=> $stable(cap_hi_o));
endmodule

// File: tb/sim_dual_half_timer.sv
`timescale 1ns/1ps
module sim_dual_half_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       pre_wr_i = 1'b0;
    logic [7:0] pre_data_i = '0;
    logic       match_lo_wr_i = 1'b0;
    logic       match_hi_wr_i = 1'b0;
    logic [7:0] match_data_i = '0;
    logic       evt_i = 1'b0;
    logic       cap_lo_i = 1'b0;
    logic       cap_hi_i = 1'b0;
    logic [7:0] cap_lo_o, cap_hi_o;
    logic       irq_lo_o, irq_hi_o;

    int  n_cmp = 0, n_bad = 0, edge_n = 0, r_edge = 0;
    int  irq_lo_n = 0, irq_hi_n = 0, kk = 0;
    bit  irq_on = 0, done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) edge_n <= edge_n + 1;

    dual_half_timer u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .pre_wr_i(pre_wr_i), .pre_data_i(pre_data_i),
        .match_lo_wr_i(match_lo_wr_i), .match_hi_wr_i(match_hi_wr_i),
        .match_data_i(match_data_i), .evt_i(evt_i),
        .cap_lo_i(cap_lo_i), .cap_hi_i(cap_hi_i),
        .cap_lo_o(cap_lo_o), .cap_hi_o(cap_hi_o),
        .irq_lo_o(irq_lo_o), .irq_hi_o(irq_hi_o)
    );

    function automatic int tmr(int k, int n, int m);
        return (k / (n + 1)) % (m + 1);
    endfunction

    function automatic int wraps(int k, int n, int m);
        return (k / (n + 1)) / (m + 1);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        if (irq_on) begin
            irq_lo_n += int'(irq_lo_o);
            irq_hi_n += int'(irq_hi_o);
        end
    endtask

    task automatic set_match(int lo, int hi);
        match_data_i = 8'(lo); match_lo_wr_i = 1'b1; step(); match_lo_wr_i = 1'b0;
        match_data_i = 8'(hi); match_hi_wr_i = 1'b1; step(); match_hi_wr_i = 1'b0;
    endtask

    task automatic arm();
        r_edge = edge_n; irq_lo_n = 0; irq_hi_n = 0; irq_on = 1;
    endtask

    task automatic restart_pre(int mode, int n);
        mode_i = 2'(mode); pre_data_i = 8'(n); pre_wr_i = 1'b1;
        step(); pre_wr_i = 1'b0;
        arm();
    endtask

    task automatic restart_mode(int mode);
        mode_i = 2'(mode);
        step();
        arm();
    endtask

    task automatic capture(bit lo, bit hi);
        irq_on = 0;
        kk = edge_n - r_edge;
        cap_lo_i = lo; cap_hi_i = hi; step();
        cap_lo_i = 1'b0; cap_hi_i = 1'b0; step();
    endtask

    task automatic pulses(int p);
        for (int i = 0; i < p; i++) begin
            evt_i = 1'b1; step(); step();
            evt_i = 1'b0; step(); step();
        end
        repeat (3) step();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R10: reset state at the outputs
        chk("R10 cap_lo", cap_lo_o, 0);
        chk("R10 cap_hi", cap_hi_o, 0);
        chk("R10 irq_lo", irq_lo_o, 0);
        chk("R10 irq_hi", irq_hi_o, 0);

        // R2 R3 R4: mode 0 sweep over prescale and match values
        for (int n = 0; n < 4; n++) begin
            for (int c = 0; c < 3; c++) begin
                int ml, mh;
                ml = (c == 0) ? 2 : (c == 1) ? 6 : 255;
                mh = (c == 0) ? 5 : (c == 1) ? 3 : 0;
                set_match(ml, mh);
                restart_pre(0, n);
                repeat (37 + 11 * n) step();
                capture(1, 1);
                chk("R2 R4 mode0 cap_lo", cap_lo_o, tmr(kk, n, ml));
                chk("R4 mode0 cap_hi", cap_hi_o, tmr(kk, n, mh));
                chk("R3 mode0 irq_lo count", irq_lo_n, wraps(kk, n, ml));
                chk("R3 mode0 irq_hi count", irq_hi_n, wraps(kk, n, mh));
            end
        end

        // R5 R8: mode 1, low timer alongside high event counter
        for (int n = 0; n < 3; n += 2) begin
            for (int p = 6; p <= 14; p += 4) begin
                set_match(4, 6);
                restart_pre(1, n);
                pulses(p);
                capture(1, 1);
                chk("R5 mode1 timer cap_lo", cap_lo_o, tmr(kk, n, 4));
                chk("R5 mode1 events cap_hi", cap_hi_o, p % 7);
                chk("R5 mode1 irq_lo count", irq_lo_n, wraps(kk, n, 4));
                chk("R5 mode1 irq_hi count", irq_hi_n, p / 7);
            end
        end

        // R6 R9: mode 2 cascade with carry and 16-bit match
        for (int n = 0; n < 2; n++) begin
            int m;
            m = (n == 0) ? 291 : 65535;
            set_match(m % 256, m / 256);
            restart_pre(2, n);
            repeat (700) step();
            capture(1, 0);
            chk("R6 R9 mode2 count", {cap_hi_o, cap_lo_o}, tmr(kk, n, m));
            chk("R6 mode2 irq_hi count", irq_hi_n, wraps(kk, n, m));
            chk("R6 mode2 irq_lo count", irq_lo_n, 0);
            begin
                int old16;
                old16 = {cap_hi_o, cap_lo_o};
                repeat (9) step();
                capture(0, 1);
                chk("R9 mode2 high strobe ignored", {cap_hi_o, cap_lo_o}, old16);
            end
        end

        // R1: restart through a mode change (mode 0 -> mode 2)
        set_match(44, 1);
        restart_pre(0, 1);
        repeat (20) step();
        restart_mode(2);
        repeat (333) step();
        capture(1, 0);
        chk("R1 mode change restart count", {cap_hi_o, cap_lo_o}, tmr(kk, 1, 300));
        chk("R1 mode change irq_hi count", irq_hi_n, wraps(kk, 1, 300));

        // R7: mode 3 16-bit event counter, past and below the match
        for (int c = 0; c < 2; c++) begin
            int m, p;
            m = (c == 0) ? 299 : 65535;
            p = (c == 0) ? 310 : 270;
            set_match(m % 256, m / 256);
            restart_pre(3, 0);
            pulses(p);
            capture(1, 0);
            chk("R7 mode3 count", {cap_hi_o, cap_lo_o}, p % (m + 1));
            chk("R7 mode3 irq_hi count", irq_hi_n, p / (m + 1));
            chk("R7 mode3 irq_lo count", irq_lo_n, 0);
        end

        // R8: capture values stay put between strobes (mode 0, held capture)
        begin
            int held;
            set_match(255, 255);
            restart_pre(0, 0);
            repeat (17) step();
            capture(1, 0);
            held = cap_lo_o;
            chk("R8 capture of running count", held, tmr(kk, 0, 255));
            repeat (5) step();
            chk("R8 capture holds", cap_lo_o, held);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule